// File: doc/BRIEF.md
# Audio Frame Sequencer with Interrupt

This block is the timebase that paces the slow envelope, length and sweep logic of a sound unit. It counts CPU cycles and raises one-cycle quarter-frame and half-frame strobes at fixed positions in a repeating loop. It can also raise a frame interrupt at the end of the loop. There are two loop modes, a four-step loop that can interrupt and a longer five-step loop that never does. There are also two region tables, one for 60 Hz and one for 50 Hz consoles, which give the step positions.

Software selects the mode and an interrupt-inhibit bit through a write strobe. The mode change and the loop restart take effect a few cycles later, and the delay depends on the get/put parity input in the cycle of the write. The inhibit bit takes effect at once. A status-read strobe clears the pending interrupt flag after the read has seen its old value. A warm reset clears the loop and the flag, drops any write still waiting, and then replays the last written mode with the inhibit bit cleared.

Each clock edge is one CPU cycle. The counter value `n` is the number of edges since the loop restarted, so the edge that restarts the loop leaves `n = 0`. An event listed at position `n` is decoded on the edge that sees `n` and is visible on the outputs for the cycle after that edge.

Top module: `frame_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, all outputs are 0. The sequencer starts in four-step mode with inhibit clear, and the first edge after reset decodes position 0.
- R2: With `region_pal`=0 and `five_step` mode 0, a quarter strobe occurs at positions 7457, 14913, 22371 and 29829. Half strobes occur at 14913 and 29829. Every half strobe comes with a quarter strobe.
- R3: With `region_pal`=0 in five-step mode (mode 1), quarter strobes occur at 7457, 14913, 22371 and 37281, and half strobes at 14913 and 37281. The interrupt flag is never set in this mode.
- R4: With `region_pal`=1, four-step mode places quarter strobes at 8313, 16627, 24939 and 33253 and half strobes at 16627 and 33253. Five-step mode places quarter strobes at 8313, 16627, 24939 and 41565 and half strobes at 16627 and 41565.
- R5: In four-step mode with inhibit clear, the interrupt flag is set by the edges at positions 29828, 29829 and 29830 (50 Hz table: 33252, 33253 and 33254). `irq_line` always equals `irq_flag`.
- R6: After the last position of a loop (four-step: 29830 or 33254; five-step: 37282 or 41566), the counter returns to 0 and the loop repeats in the same mode.
- R7: A write restarts the loop at the third edge after the write edge if `apu_phase`=1 during the write, and at the fourth edge otherwise. Until then the old mode keeps running. The inhibit bit takes effect on the write edge itself.
- R8: On the restart edge, selecting five-step mode gives one quarter and one half strobe together. Selecting four-step mode gives neither, and the flag is not set on that edge.
- R9: A write with inhibit=1 clears the flag on its own edge, and the flag stays clear while inhibit is 1.
- R10: A `status_rd` clears the flag on that edge. If the same edge also sets the flag (R5), the set wins.
- R11: `warm_rst` clears the counter, the flag, the inhibit bit and the strobes, and drops any waiting write. It then schedules a write of the last written mode with inhibit clear, with the delay of R7 taken from `apu_phase` on the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-cycle clock |
| rst | input | 1 | Synchronous active-high cold reset |
| warm_rst | input | 1 | Synchronous warm reset request (R11) |
| mode_wr | input | 1 | Mode/inhibit register write strobe |
| wr_five_step | input | 1 | Written mode: 0 four-step, 1 five-step |
| wr_irq_inhibit | input | 1 | Written interrupt-inhibit bit |
| status_rd | input | 1 | Status register read strobe |
| region_pal | input | 1 | Step table select: 0 60 Hz, 1 50 Hz |
| apu_phase | input | 1 | Get/put parity, 1 during an APU cycle |
| quarter_pulse | output | 1 | Quarter-frame strobe |
| half_pulse | output | 1 | Half-frame strobe |
| irq_flag | output | 1 | Frame interrupt flag |
| irq_line | output | 1 | Interrupt request line |

## Verification
A wrong counter value moves every later strobe and the interrupt window by the same number of cycles. This shows up at the first step position after the fault, within one quarter loop, and it lasts until the next write. A wrong pending-write state shows up three or four cycles after a write, as a restart strobe that is missing or comes at the wrong edge. After that the whole loop phase is shifted. A wrong flag or inhibit state shows up on `irq_flag` and `irq_line` on the edge right after a read or an inhibit write, or in the three-cycle window at the end of the loop.

// File: rtl/fs_pkg.sv
package fs_pkg;
  // Step positions, in cycles since the loop restarted
  localparam int NTSC_Q1   = 7457;
  localparam int NTSC_Q2   = 14913;
  localparam int NTSC_Q3   = 22371;
  localparam int NTSC_IRQ  = 29828;
  localparam int NTSC_END5 = 37281;
  localparam int PAL_Q1    = 8313;
  localparam int PAL_Q2    = 16627;
  localparam int PAL_Q3    = 24939;
  localparam int PAL_IRQ   = 33252;
  localparam int PAL_END5  = 41565;
  localparam int MAX_POS   = PAL_END5 + 1;

  typedef struct packed {
    logic qtr;
    logic half;
    logic irq;
    logic last;
  } fs_ev_t;
endpackage

// File: rtl/fs_step_decode.sv
module fs_step_decode
  import fs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             region_pal,
  input  logic             five_step,
  output fs_ev_t           ev
);
  logic [CNT_W-1:0] p_q1, p_q2, p_q3, p_irq, p_end5;
  logic at_q1, at_q2, at_q3, at_i0, at_i1, at_i2, at_e5, at_w5;

  assign p_q1   = region_pal ? CNT_W'(PAL_Q1)   : CNT_W'(NTSC_Q1);
  assign p_q2   = region_pal ? CNT_W'(PAL_Q2)   : CNT_W'(NTSC_Q2);
  assign p_q3   = region_pal ? CNT_W'(PAL_Q3)   : CNT_W'(NTSC_Q3);
  assign p_irq  = region_pal ? CNT_W'(PAL_IRQ)  : CNT_W'(NTSC_IRQ);
  assign p_end5 = region_pal ? CNT_W'(PAL_END5) : CNT_W'(NTSC_END5);

  assign at_q1 = (cnt == p_q1);
  assign at_q2 = (cnt == p_q2);
  assign at_q3 = (cnt == p_q3);
  assign at_i0 = (cnt == p_irq);
  assign at_i1 = (cnt == p_irq + CNT_W'(1));
  assign at_i2 = (cnt == p_irq + CNT_W'(2));
  assign at_e5 = (cnt == p_end5);
  assign at_w5 = (cnt == p_end5 + CNT_W'(1));

  always_comb begin
    ev = '0;
    if (five_step) begin
      ev.qtr  = at_q1 | at_q2 | at_q3 | at_e5;
      ev.half = at_q2 | at_e5;
      ev.last = at_w5;
    end else begin
      ev.qtr  = at_q1 | at_q2 | at_q3 | at_i1;
      ev.half = at_q2 | at_i1;
      ev.irq  = at_i0 | at_i1 | at_i2;
      ev.last = at_i2;
    end
  end
endmodule

// File: rtl/fs_write_ctl.sv
module fs_write_ctl (
  input  logic clk,
  input  logic rst,
  input  logic warm,
  input  logic wr,
  input  logic wr_five,
  input  logic wr_inh,
  input  logic phase,
  output logic mode_q,
  output logic inh_q,
  output logic apply,
  output logic pend_mode
);
  localparam int DLY_W = 2;
  localparam logic [DLY_W-1:0] DLY_ON  = DLY_W'(2);
  localparam logic [DLY_W-1:0] DLY_OFF = DLY_W'(3);

  logic             last_mode;
  logic             pend;
  logic [DLY_W-1:0] dly;

  assign apply = pend && (dly == '0) && !warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= 1'b0;
      inh_q     <= 1'b0;
      last_mode <= 1'b0;
      pend      <= 1'b0;
      pend_mode <= 1'b0;
      dly       <= '0;
    end else if (warm) begin
      inh_q     <= 1'b0;
      pend      <= 1'b1;
      dly       <= phase ? DLY_ON : DLY_OFF;
      pend_mode <= last_mode;
    end else begin
      if (apply) mode_q <= pend_mode;
      if (wr) begin
        inh_q     <= wr_inh;
        last_mode <= wr_five;
        pend      <= 1'b1;
        dly       <= phase ? DLY_ON : DLY_OFF;
        pend_mode <= wr_five;
      end else if (pend) begin
        if (dly == '0) pend <= 1'b0;
        else dly <= dly - 1'b1;
      end
    end
  end

  // R7
  min_delay_chk: assert property (@(posedge clk) disable iff (rst)
    apply |-> !$past(wr));
endmodule

// File: rtl/fs_irq_flag.sv
module fs_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic warm,
  input  logic set_req,
  input  logic inh_eff,
  input  logic clr_rd,
  input  logic clr_inh,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst || warm)               flag <= 1'b0;
    else if (set_req && !inh_eff)  flag <= 1'b1;
    else if (clr_rd || clr_inh)    flag <= 1'b0;
  end

  // R9
  inh_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_inh |=> !flag);
  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_rd && !set_req) |=> !flag);
  // R5
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_req && !inh_eff && !warm) |=> flag);
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import fs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic warm_rst,
  input  logic mode_wr,
  input  logic wr_five_step,
  input  logic wr_irq_inhibit,
  input  logic status_rd,
  input  logic region_pal,
  input  logic apu_phase,
  output logic quarter_pulse,
  output logic half_pulse,
  output logic irq_flag,
  output logic irq_line
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_POS);

  logic [CNT_W-1:0] cnt;
  logic   mode_q, inh_q, apply, pend_mode, inh_eff, set_req;
  fs_ev_t ev;

  fs_write_ctl u_wctl (
    .clk(clk), .rst(rst), .warm(warm_rst), .wr(mode_wr),
    .wr_five(wr_five_step), .wr_inh(wr_irq_inhibit), .phase(apu_phase),
    .mode_q(mode_q), .inh_q(inh_q), .apply(apply), .pend_mode(pend_mode)
  );

  fs_step_decode #(.CNT_W(CNT_W)) u_dec (
    .cnt(cnt), .region_pal(region_pal), .five_step(mode_q), .ev(ev)
  );

  assign inh_eff = mode_wr ? wr_irq_inhibit : inh_q;
  assign set_req = ev.irq && !apply;

  fs_irq_flag u_irq (
    .clk(clk), .rst(rst), .warm(warm_rst), .set_req(set_req),
    .inh_eff(inh_eff), .clr_rd(status_rd),
    .clr_inh(mode_wr && wr_irq_inhibit && !warm_rst), .flag(irq_flag)
  );

  assign irq_line = irq_flag;

  always_ff @(posedge clk) begin
    if (rst || warm_rst) begin
      cnt           <= '0;
      quarter_pulse <= 1'b0;
      half_pulse    <= 1'b0;
    end else if (apply) begin
      cnt           <= '0;
      quarter_pulse <= pend_mode;
      half_pulse    <= pend_mode;
    end else begin
      quarter_pulse <= ev.qtr;
      half_pulse    <= ev.half;
      cnt           <= ev.last ? '0 : cnt + 1'b1;
    end
  end

  // R8
  five_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (apply && pend_mode) |=> (quarter_pulse && half_pulse));
  // R2
  half_has_qtr_chk: assert property (@(posedge clk) disable iff (rst)
    half_pulse |-> quarter_pulse);
  // R3
  irq_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> !mode_q);
  // R11
  warm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    warm_rst |=> (cnt == '0 && !irq_flag && !quarter_pulse && !half_pulse));
  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX);
endmodule

// File: tb/frame_seq_test.sv
module frame_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst, warm_rst, mode_wr, wr_five_step, wr_irq_inhibit;
  logic status_rd, region_pal, apu_phase;
  logic quarter_pulse, half_pulse, irq_flag, irq_line;

  frame_seq uut (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .mode_wr(mode_wr),
    .wr_five_step(wr_five_step), .wr_irq_inhibit(wr_irq_inhibit),
    .status_rd(status_rd), .region_pal(region_pal), .apu_phase(apu_phase),
    .quarter_pulse(quarter_pulse), .half_pulse(half_pulse),
    .irq_flag(irq_flag), .irq_line(irq_line)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string cur_req = "R1";

  int m_cnt, m_dly;
  bit m_mode, m_inh, m_last, m_pend, m_pmode, m_flag, m_q, m_h;

  // returns {quarter, half, irq, last} from the requirement step lists
  function automatic logic [3:0] ev_fn(bit pal, bit five, int c);
    int a = pal ? 8313 : 7457;
    int b = pal ? 16627 : 14913;
    int d = pal ? 24939 : 22371;
    int e = pal ? 33252 : 29828;
    int f = pal ? 41565 : 37281;
    logic [3:0] r = 4'b0;
    if (five) begin
      r[3] = (c == a) || (c == b) || (c == d) || (c == f);
      r[2] = (c == b) || (c == f);
      r[0] = (c == f + 1);
    end else begin
      r[3] = (c == a) || (c == b) || (c == d) || (c == e + 1);
      r[2] = (c == b) || (c == e + 1);
      r[1] = (c >= e) && (c <= e + 2);
      r[0] = (c == e + 2);
    end
    return r;
  endfunction

  task automatic model_step();
    logic [3:0] ev;
    bit apply, inh_eff, setr, clr, old_pmode;
    if (rst) begin
      m_cnt = 0; m_dly = 0; m_mode = 0; m_inh = 0; m_last = 0;
      m_pend = 0; m_pmode = 0; m_flag = 0; m_q = 0; m_h = 0;
    end else if (warm_rst) begin
      m_cnt = 0; m_flag = 0; m_inh = 0; m_pend = 1;
      m_dly = apu_phase ? 2 : 3; m_pmode = m_last; m_q = 0; m_h = 0;
    end else begin
      apply = m_pend && (m_dly == 0);
      inh_eff = mode_wr ? wr_irq_inhibit : m_inh;
      ev = ev_fn(region_pal, m_mode, m_cnt);
      setr = ev[1] && !apply;
      clr = status_rd || (mode_wr && wr_irq_inhibit);
      old_pmode = m_pmode;
      if (apply) begin
        m_mode = old_pmode; m_cnt = 0; m_q = old_pmode; m_h = old_pmode;
      end else begin
        m_q = ev[3]; m_h = ev[2];
        m_cnt = ev[0] ? 0 : m_cnt + 1;
      end
      if (mode_wr) begin
        m_inh = wr_irq_inhibit; m_last = wr_five_step; m_pend = 1;
        m_dly = apu_phase ? 2 : 3; m_pmode = wr_five_step;
      end else if (m_pend) begin
        if (m_dly == 0) m_pend = 0;
        else m_dly = m_dly - 1;
      end
      if (setr && !inh_eff) m_flag = 1;
      else if (clr) m_flag = 0;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    checks++;
    if (quarter_pulse !== m_q || half_pulse !== m_h ||
        irq_flag !== m_flag || irq_line !== m_flag) begin
      errors++;
      $display("FAIL %s at %0t: q/h/flag/line actual=%b%b%b%b expected=%b%b%b%b",
               cur_req, $time, quarter_pulse, half_pulse, irq_flag, irq_line,
               m_q, m_h, m_flag, m_flag);
    end
    mode_wr = 0; status_rd = 0; warm_rst = 0;
  endtask

  task automatic do_write(bit five, bit inh, bit ph);
    mode_wr = 1; wr_five_step = five; wr_irq_inhibit = inh; apu_phase = ph;
    cyc();
  endtask

  initial begin
    rst = 1; warm_rst = 0; mode_wr = 0; wr_five_step = 0; wr_irq_inhibit = 0;
    status_rd = 0; region_pal = 0; apu_phase = 0;
    @(negedge clk);
    cur_req = "R1";
    repeat (3) cyc();
    rst = 0;
    cur_req = "R1/R2/R5/R6";
    repeat (29835) cyc();
    cur_req = "R10";
    status_rd = 1; cyc();
    cyc();
    while (m_cnt != 29828) cyc();
    status_rd = 1; cyc();          // set wins over read on the same edge
    cur_req = "R9";
    do_write(0, 1, 1);             // inhibit on the middle window edge
    repeat (6) cyc();
    cur_req = "R7/R8/R3/R6";
    do_write(1, 0, 1);
    repeat (37300) cyc();
    cur_req = "R4/R5/R7";
    region_pal = 1;
    do_write(0, 0, 0);
    repeat (33270) cyc();
    cur_req = "R4/R8";
    do_write(1, 0, 1);
    repeat (41580) cyc();
    cur_req = "R11";
    region_pal = 0;
    do_write(0, 0, 0);
    do_write(1, 0, 1);
    cyc();
    warm_rst = 1; apu_phase = 0; cyc();
    repeat (20) cyc();
    cur_req = "R7/R9/R10/R11";
    void'($urandom(32'd4242));
    for (int i = 0; i < 6000; i++) begin
      apu_phase = $urandom_range(0, 1);
      status_rd = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 299) == 0) begin
        mode_wr = 1;
        wr_five_step = $urandom_range(0, 1);
        wr_irq_inhibit = $urandom_range(0, 1);
      end
      warm_rst = ($urandom_range(0, 1499) == 0);
      cyc();
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL %s watchdog: actual=running expected=done", cur_req);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule